// File: doc/BRIEF.md
# Interrupt Redirection Controller with Request Tracking

This block collects a set of external interrupt lines (24 by default) and turns each asserted line into a single interrupt message, made of a vector and a valid flag, for a processor-side interrupt unit. Every line has its own redirection entry. The entry holds the vector to send, an active-low polarity option, an edge or level trigger selection and a mask. The block keeps a per-line request bit for pending work. For level-mode lines it also keeps an "in service" flag, which is set when the consumer takes the message. The flag is cleared when an end-of-interrupt (EOI) broadcast arrives carrying the same vector.

Software reaches the entries through two locations. One is an index register. The other is a 32-bit data window that shows the register the index selects. Entry n occupies index 0x10+2n (low half) and index 0x11+2n (high half). Only full-width accesses to the window take effect.

Only one message is offered at a time. It stays on the output until the consumer accepts it. When several lines are pending, the lowest-numbered one goes first.

Top module: `irq_router`

## Requirements
- R1: All 24 lines, 0 to 23, can raise messages. When several unmasked lines are pending, they are delivered in ascending line order, one message at a time.
- R2: With the polarity bit set, a line is active low. A line sitting high does not fire. Driving it low counts as an assertion.
- R3: In edge mode, an active-going transition on an unmasked line produces exactly one message carrying that entry's vector. The request bit clears when the message is accepted.
- R4: An active-going transition on a masked edge-mode line is dropped. Unmasking the line later produces no message.
- R5: In level mode, an asserted unmasked line produces a message. On acceptance, the in-service flag (low-half bit 14) is set, and no further message comes from that line until a matching EOI.
- R6: An EOI whose vector matches a level-mode entry clears that entry's in-service flag. If the line is still asserted, a new message follows. An EOI with a different vector, or an EOI after the line has dropped, produces no message.
- R7: A request latched in edge mode does not survive a switch to level mode. If the line is inactive after the switch, no message is produced.
- R8: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_vector does not change.
- R9: With sw_sel=0, the index register is read and written directly. The low half of entry n is at index 0x10+2n: bits 7:0 hold the vector, bit 13 polarity, bit 14 the in-service flag (read only), bit 15 trigger (1 = level) and bit 16 mask. The high half at 0x11+2n stores bits 31:24. All other bits read 0. An index outside the entry range reads 0.
- R10: A data-window write with sw_full=0 changes nothing. A data-window read with sw_full=0 returns 0.
- R11: After reset, no message is offered and every entry's low half reads 0x0001_0000, which means masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 24 | Raw interrupt lines |
| sw_sel | input | 1 | 0 = index register, 1 = data window |
| sw_wr | input | 1 | Write strobe |
| sw_rd | input | 1 | Read strobe |
| sw_full | input | 1 | 1 = full 32-bit access |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, valid in the cycle sw_rd is high |
| msg_valid | output | 1 | Interrupt message offered |
| msg_vector | output | 8 | Vector of the offered message |
| msg_ready | input | 1 | Consumer accepts the message |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |

## Verification
The routing path is driven with several patterns:
- A single rising edge on an unmasked line.
- An idle-high line under active-low polarity, which must stay silent until it falls.
- A pulse on a masked line.
- A held level line taken through accept, a wrong-vector EOI, a matching EOI while still high, and a matching EOI after release.
- Three lines raised in the same cycle.

The single edge and the held level separate the two trigger modes. The wrong-vector and released-line EOIs show that re-delivery depends on both the vector match and the line level. The same-cycle burst exposes the priority order and confirms that the upper lines work.

A separate sequence latches an edge request while another message is held, then switches that line to level mode. This shows whether a stale request can leak through.

// File: rtl/irq_router_pkg.sv
// Package: shared entry type and register-layout constants for the
// interrupt redirection controller.
package irq_router_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DATA_W = 32;

    // bit positions inside the low and high halves of an entry
    localparam int LO_POL_BIT  = 13;
    localparam int LO_BUSY_BIT = 14;
    localparam int LO_TRIG_BIT = 15;
    localparam int LO_MASK_BIT = 16;
    localparam int HI_DEST_LSB = 24;

    // first index of the entry table
    localparam int ENTRY_BASE = 16;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;   // 1 = level
        logic              pol;    // 1 = active low
        logic [VEC_W-1:0]  vec;
    } route_entry_t;

endpackage

// File: rtl/irq_pin_cell.sv
// Module: irq_pin_cell
// Conditions one interrupt line: it applies polarity, detects edges,
// keeps the request bit and, in level mode, the in-service flag.
// Assumes the raw line is already synchronous to clk.
module irq_pin_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pol,
    input  logic trig,
    input  logic mask,
    input  logic accept,
    input  logic eoi_hit,
    output logic req,
    output logic busy,
    output logic pending
);

    logic act;
    logic act_q;
    logic trig_q;

    // Polarity folded in before any trigger logic
    assign act = raw_in ^ pol;

    // Track the previous active level and trigger mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            act_q  <= act;
            trig_q <= trig;
        end
    end

    // Request bit: set by edge or follows level; dropped on mode change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (trig != trig_q) begin
            req <= 1'b0;
        end else if (trig) begin
            req <= act;
        end else if (act && !act_q && !mask) begin
            req <= 1'b1;
        end else if (accept) begin
            req <= 1'b0;
        end
    end

    // In-service flag: level mode only, set on delivery, cleared by EOI
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (!trig) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (eoi_hit) begin
            busy <= 1'b0;
        end
    end

    assign pending = req && !mask && !busy;

endmodule

// File: rtl/irq_router_arb.sv
// Module: irq_router_arb
// Picks the lowest-numbered pending line, holds its message until the
// consumer accepts, and returns a one-hot accept pulse to the lines.
// Assumes pending bits already reflect mask and in-service state.
module irq_router_arb #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PINS-1:0]               pending,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]    vec_tab,
    input  logic                              msg_ready,
    output logic                              msg_valid,
    output logic [VEC_W-1:0]                  msg_vector,
    output logic [NUM_PINS-1:0]               accept
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             found;
    logic [PIN_W-1:0] pick;
    logic [PIN_W-1:0] held_pin;
    logic             take;

    // Fixed priority: lowest index wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                pick  = PIN_W'(i);
            end
        end
    end

    assign take = msg_valid && msg_ready;

    // Message holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
            held_pin   <= '0;
        end else if (take) begin
            msg_valid <= 1'b0;
        end else if (!msg_valid && found) begin
            msg_valid  <= 1'b1;
            msg_vector <= vec_tab[pick];
            held_pin   <= pick;
        end
    end

    // One-hot accept returned to the granted line
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_acc
        assign accept[g] = take && (held_pin == PIN_W'(g));
    end

endmodule

// File: rtl/irq_router_regs.sv
// Module: irq_router_regs
// Holds the index register and the redirection entries, decodes the
// data window and rejects window accesses narrower than 32 bits.
// Assumes one access per cycle; read data is combinational.
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sw_sel,
    input  logic                         sw_wr,
    input  logic                         sw_rd,
    input  logic                         sw_full,
    input  logic [DATA_W-1:0]            sw_wdata,
    output logic [DATA_W-1:0]            sw_rdata,
    input  logic [NUM_PINS-1:0]          busy,
    output route_entry_t [NUM_PINS-1:0]  ent
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int SPAN  = 2 * NUM_PINS;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] off;
    logic             in_range;
    logic             hi_half;
    logic [PIN_W-1:0] sel;
    logic             win_wr;
    logic [DATA_W-1:0] lo_word;
    logic [DATA_W-1:0] hi_word;

    assign off      = idx_q - IDX_W'(ENTRY_BASE);
    assign in_range = (int'(idx_q) >= ENTRY_BASE) && (int'(idx_q) < ENTRY_BASE + SPAN);
    assign hi_half  = off[0];
    assign sel      = off[PIN_W:1];
    assign win_wr   = sw_wr && sw_sel && sw_full && in_range;

    // Index register accepts any access width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sw_wr && !sw_sel) begin
            idx_q <= sw_wdata[IDX_W-1:0];
        end
    end

    // One entry register per line, reset masked
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '{dest: '0, mask: 1'b1, trig: 1'b0, pol: 1'b0, vec: '0};
            end else if (win_wr && sel == PIN_W'(g)) begin
                if (hi_half) begin
                    ent[g].dest <= sw_wdata[HI_DEST_LSB +: DEST_W];
                end else begin
                    ent[g].vec  <= sw_wdata[VEC_W-1:0];
                    ent[g].pol  <= sw_wdata[LO_POL_BIT];
                    ent[g].trig <= sw_wdata[LO_TRIG_BIT];
                    ent[g].mask <= sw_wdata[LO_MASK_BIT];
                end
            end
        end
    end

    // Assemble the two halves of the selected entry
    always_comb begin
        lo_word = '0;
        hi_word = '0;
        if (in_range) begin
            lo_word[VEC_W-1:0]   = ent[sel].vec;
            lo_word[LO_POL_BIT]  = ent[sel].pol;
            lo_word[LO_BUSY_BIT] = busy[sel];
            lo_word[LO_TRIG_BIT] = ent[sel].trig;
            lo_word[LO_MASK_BIT] = ent[sel].mask;
            hi_word[HI_DEST_LSB +: DEST_W] = ent[sel].dest;
        end
    end

    // Read mux; narrow window reads return zero
    always_comb begin
        sw_rdata = '0;
        if (sw_rd) begin
            if (!sw_sel) begin
                sw_rdata = DATA_W'(idx_q);
            end else if (sw_full) begin
                sw_rdata = hi_half ? hi_word : lo_word;
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: irq_router
// Top of the interrupt redirection controller: per-line conditioning,
// the entry registers and the message arbiter.
// Assumes inputs are synchronous to clk and one consumer takes messages.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                sw_sel,
    input  logic                sw_wr,
    input  logic                sw_rd,
    input  logic                sw_full,
    input  logic [31:0]         sw_wdata,
    output logic [31:0]         sw_rdata,
    output logic                msg_valid,
    output logic [7:0]          msg_vector,
    input  logic                msg_ready,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);

    route_entry_t [NUM_PINS-1:0]          ent;
    logic [NUM_PINS-1:0][VEC_W-1:0]       vec_tab;
    logic [NUM_PINS-1:0]                  req_v;
    logic [NUM_PINS-1:0]                  busy_v;
    logic [NUM_PINS-1:0]                  pend_v;
    logic [NUM_PINS-1:0]                  accept_v;
    logic [NUM_PINS-1:0]                  trig_v;
    logic [NUM_PINS-1:0]                  mask_v;

    irq_router_regs #(.NUM_PINS(NUM_PINS), .IDX_W(8)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_sel   (sw_sel),
        .sw_wr    (sw_wr),
        .sw_rd    (sw_rd),
        .sw_full  (sw_full),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .busy     (busy_v),
        .ent      (ent)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign vec_tab[g] = ent[g].vec;
        assign trig_v[g]  = ent[g].trig;
        assign mask_v[g]  = ent[g].mask;

        irq_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (irq_in[g]),
            .pol     (ent[g].pol),
            .trig    (ent[g].trig),
            .mask    (ent[g].mask),
            .accept  (accept_v[g]),
            .eoi_hit (eoi_valid && (ent[g].vec == eoi_vector)),
            .req     (req_v[g]),
            .busy    (busy_v[g]),
            .pending (pend_v[g])
        );
    end

    irq_router_arb #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pend_v),
        .vec_tab    (vec_tab),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .accept     (accept_v)
    );

endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Property checker bound into irq_router.
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         msg_valid,
    input  logic                         msg_ready,
    input  logic [7:0]                   msg_vector,
    input  logic                         sw_sel,
    input  logic                         sw_wr,
    input  logic                         sw_rd,
    input  logic                         sw_full,
    input  logic [31:0]                  sw_rdata,
    input  logic                         eoi_valid,
    input  logic [7:0]                   eoi_vector,
    input  logic [NUM_PINS-1:0]          trig_v,
    input  logic [NUM_PINS-1:0]          mask_v,
    input  logic [NUM_PINS-1:0]          req_v,
    input  logic [NUM_PINS-1:0]          busy_v,
    input  logic [NUM_PINS-1:0]          accept_v,
    input  route_entry_t [NUM_PINS-1:0]  ent
);

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)); // R8

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept_v) && ((accept_v == '0) || msg_valid)); // R1

    AST_MASKED_EDGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v & $past(~trig_v & mask_v & ~req_v)) == '0); // R4

    AST_NARROW_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr && sw_sel && !sw_full |=> $stable(ent)); // R10

    AST_NARROW_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd && sw_sel && !sw_full |-> sw_rdata == '0); // R10

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
        AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            busy_v[g] |-> !accept_v[g]); // R5

        AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_valid && trig_v[g] && (ent[g].vec == eoi_vector) && !accept_v[g]
            |=> !busy_v[g]); // R6
    end

endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .sw_sel     (sw_sel),
    .sw_wr      (sw_wr),
    .sw_rd      (sw_rd),
    .sw_full    (sw_full),
    .sw_rdata   (sw_rdata),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .trig_v     (trig_v),
    .mask_v     (mask_v),
    .req_v      (req_v),
    .busy_v     (busy_v),
    .accept_v   (accept_v),
    .ent        (ent)
);

// File: tb/irq_router_test.sv
// Directed bench for irq_router: one task per scenario.
module irq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_in = 24'h000080;   // line 7 idles high
    logic        sw_sel = 1'b0, sw_wr = 1'b0, sw_rd = 1'b0, sw_full = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic        msg_ready = 1'b0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_full(sw_full),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_ready(msg_ready),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic sel, input logic full, input logic [31:0] d);
        @(negedge clk);
        sw_sel = sel; sw_full = full; sw_wdata = d; sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic sel, input logic full, output logic [31:0] d);
        @(negedge clk);
        sw_sel = sel; sw_full = full; sw_rd = 1'b1;
        #1 d = sw_rdata;
        sw_rd = 1'b0;
    endtask

    task automatic set_idx(input int idx);
        sw_write(1'b0, 1'b0, 32'(idx));
    endtask

    task automatic read_lo(input int n, output logic [31:0] d);
        set_idx(16 + 2 * n);
        sw_read(1'b1, 1'b1, d);
    endtask

    task automatic prog(input int n, input logic [7:0] vec, input logic pol,
                        input logic trig, input logic mask);
        set_idx(16 + 2 * n);
        sw_write(1'b1, 1'b1, {15'd0, mask, trig, 1'b0, pol, 5'd0, vec});
    endtask

    task automatic take_msg(input string req, input logic [7:0] exp);
        bit got = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1; break; end
        end
        check(req, {31'd0, got}, 32'd1);
        if (got) begin
            check(req, {24'd0, msg_vector}, {24'd0, exp});
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic no_msg(input string req, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // R11: reset state
    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R11 no message", {31'd0, msg_valid}, 32'd0);
        read_lo(0, d);  check("R11 entry0", d, 32'h0001_0000);
        read_lo(23, d); check("R11 entry23", d, 32'h0001_0000);
    endtask

    // R9: register map
    task automatic t_regmap();
        logic [31:0] d;
        set_idx(16 + 10);
        sw_write(1'b1, 1'b1, 32'hFFFF_FFFF);
        sw_read(1'b1, 1'b1, d);
        check("R9 low fields", d, 32'h0001_A0FF);
        set_idx(17 + 10);
        sw_write(1'b1, 1'b1, 32'hAB00_1234);
        sw_read(1'b1, 1'b1, d);
        check("R9 high half", d, 32'hAB00_0000);
        sw_read(1'b0, 1'b0, d);
        check("R9 index readback", d, 32'h0000_001B);
        set_idx(8'h40);
        sw_read(1'b1, 1'b1, d);
        check("R9 out of range", d, 32'h0);
        prog(5, 8'h00, 1'b0, 1'b0, 1'b1);
        read_lo(5, d);
        check("R9 restore", d, 32'h0001_0000);
    endtask

    // R10: narrow window accesses
    task automatic t_narrow();
        logic [31:0] d;
        set_idx(16 + 10);
        sw_write(1'b1, 1'b0, 32'h0000_0055);
        sw_read(1'b1, 1'b1, d);
        check("R10 narrow write ignored", d, 32'h0001_0000);
        sw_read(1'b1, 1'b0, d);
        check("R10 narrow read zero", d, 32'h0);
    endtask

    // R3 and R8: edge delivery and holding
    task automatic t_edge();
        bit ok = 1;
        prog(3, 8'h33, 1'b0, 1'b0, 1'b0);
        @(negedge clk); irq_in[3] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (msg_valid) break;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h33) ok = 0;
        end
        check("R8 held until ready", {31'd0, ok}, 32'd1);
        take_msg("R3 edge vector", 8'h33);
        no_msg("R3 single message per edge", 6);
        irq_in[3] = 1'b0;
    endtask

    // R2: active-low line
    task automatic t_polarity();
        prog(7, 8'h47, 1'b1, 1'b0, 1'b0);
        no_msg("R2 idle high silent", 5);
        @(negedge clk); irq_in[7] = 1'b0;
        take_msg("R2 falling fires", 8'h47);
        @(negedge clk); irq_in[7] = 1'b1;
        prog(7, 8'h47, 1'b1, 1'b0, 1'b1);
    endtask

    // R4: masked edge dropped
    task automatic t_masked_edge();
        prog(9, 8'h59, 1'b0, 1'b0, 1'b1);
        @(negedge clk); irq_in[9] = 1'b1;
        @(negedge clk); @(negedge clk); irq_in[9] = 1'b0;
        prog(9, 8'h59, 1'b0, 1'b0, 1'b0);
        no_msg("R4 masked edge dropped", 6);
    endtask

    // R7: stale edge request removed by switch to level
    task automatic t_switch();
        prog(1, 8'h41, 1'b0, 1'b0, 1'b0);
        @(negedge clk); irq_in[1] = 1'b1;
        repeat (3) @(negedge clk);          // message for line 1 now held
        irq_in[9] = 1'b1;
        @(negedge clk); @(negedge clk); irq_in[9] = 1'b0;
        prog(9, 8'h59, 1'b0, 1'b1, 1'b0);
        take_msg("R7 held message first", 8'h41);
        no_msg("R7 no stale request", 6);
        @(negedge clk); irq_in[9] = 1'b1;
        take_msg("R7 level works after switch", 8'h59);
        @(negedge clk); irq_in[9] = 1'b0; irq_in[1] = 1'b0;
        send_eoi(8'h59);
        prog(9, 8'h59, 1'b0, 1'b1, 1'b1);
        prog(1, 8'h41, 1'b0, 1'b0, 1'b1);
    endtask

    // R5 and R6: level delivery, in-service, EOI
    task automatic t_level();
        logic [31:0] d;
        prog(12, 8'h6C, 1'b0, 1'b1, 1'b0);
        @(negedge clk); irq_in[12] = 1'b1;
        take_msg("R5 level fires", 8'h6C);
        read_lo(12, d);
        check("R5 in-service bit set", d, 32'h0000_C06C);
        no_msg("R5 blocked until EOI", 6);
        send_eoi(8'h6D);
        no_msg("R6 other vector ignored", 5);
        send_eoi(8'h6C);
        take_msg("R6 refire while asserted", 8'h6C);
        @(negedge clk); irq_in[12] = 1'b0;
        @(negedge clk);
        send_eoi(8'h6C);
        no_msg("R6 no refire after release", 6);
        read_lo(12, d);
        check("R6 in-service cleared", d, 32'h0000_806C);
    endtask

    // R1: ascending order and upper lines
    task automatic t_priority();
        prog(20, 8'h94, 1'b0, 1'b0, 1'b0);
        prog(2,  8'h82, 1'b0, 1'b0, 1'b0);
        prog(23, 8'h97, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        irq_in[20] = 1'b1; irq_in[2] = 1'b1; irq_in[23] = 1'b1;
        take_msg("R1 first lowest", 8'h82);
        take_msg("R1 second", 8'h94);
        take_msg("R1 line 23", 8'h97);
        no_msg("R1 burst drained", 5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_narrow();
        t_edge();
        t_polarity();
        t_masked_edge();
        t_switch();
        t_level();
        t_priority();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule